// File: doc/BRIEF.md
# Cascaded Timer Interrupt Generator

The block holds two timer pairs that share one periodic tick enable, nominally 64 kHz. Each pair chains two 16-bit down-counters. The first counter is a reloading rate divider. Each time it reaches its terminal count, it sends one step into the second counter. If the second counter is already at zero when a step arrives, the pair raises a one-clock interrupt pulse. The second counter then wraps to 65535 and keeps counting. A divider value of 64000 gives one step per second, so the second counter measures long intervals in seconds.

Software reaches the four counters through a byte-wide port. Every 16-bit value is written as two bytes, low byte first. While only half of a value has been written, the pair that owns the counter ignores ticks. Reads also return the low byte first. The high byte is captured at the moment the low byte is read, so the two halves always belong to the same count. The two pairs drive fixed lines of an 8-bit interrupt request vector that an interrupt controller decodes.

Top module: `cascade_timer`

## Requirements
- R1: After reset, every counter reads 0, the interrupt vector is 0, both byte pointers of every counter point to the low byte, and both pairs are idle.
- R2: Address bit 1 selects the pair. Address bit 0 selects the stage: 0 is the divider and 1 is the interval counter. So addresses 0 and 1 belong to pair 0, and addresses 2 and 3 belong to pair 1.
- R3: A write to a counter stores the byte as the low half and does not change the counter. The next write to the same counter supplies the high half and loads the full 16-bit value in that cycle.
- R4: While either counter of a pair holds a written low byte whose high byte has not yet been written, the pair ignores ticks and neither of its counts changes. Counting resumes on the first tick after the high byte is written.
- R5: A pair ignores ticks until its divider has been fully loaded once after reset. Loading only the interval counter does not start the pair.
- R6: On each accepted tick, a divider holding 2 or more decrements. A divider holding 1 or 0 reloads from its last loaded divisor and issues one cascade step. A divisor N of 1 or more therefore gives one step every N ticks, and a divisor of 0 gives one step on every tick.
- R7: On a cascade step, an interval counter at 0 causes an interrupt. In every case the interval counter then decrements, so from 0 it wraps to 65535.
- R8: An interrupt is a pulse exactly one clock wide, asserted in the cycle after the edge at which the tick was accepted. Pair 0 drives bit 6 of the 8-bit vector and pair 1 drives bit 0.
- R9: A read returns the live low byte and captures the high byte at that moment. The next read of the same counter returns the captured high byte, even if the count has changed since.
- R10: Loading the interval counter while its pair is running replaces its value and does not restart or reload the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 64 kHz count rate |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; advances the counter's read byte pointer |
| addr | input | 2 | Counter select: {pair, stage} |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte currently presented for the addressed counter |
| irq_lines | output | 8 | Interrupt request vector; bit 6 from pair 0, bit 0 from pair 1 |

## Verification
Checks that run on every cycle cover four points. The interrupt vector clears after reset. Any interrupt bit falls in the cycle after it rises. An interrupt appears only one edge after a tick. A divider holds its count whenever a half-written value halts its pair or no tick arrives. Only the bench scenarios can show the arithmetic: the reload period for divisors 0, 1 and larger, the wrap from zero to 65535, the routing of each pair to its vector bit, and the high-byte capture on reads. They also show that a pending low byte leaves the loaded value untouched and that a reload of the interval counter leaves the divider's phase intact.

// File: rtl/cascade_timer_pkg.sv
// Shared sizes and types for the cascaded timer block.
// Assumes a byte-wide host port and counters exactly two bytes wide.
package cascade_timer_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int PAIRS     = 2;
    localparam int STAGES    = 2;
    localparam int CTRS      = PAIRS * STAGES;
    localparam int SEL_W     = $clog2(CTRS);
    localparam int IRQ_W     = 8;
    localparam int IRQ_IDX_W = $clog2(IRQ_W);

    typedef enum logic {
        STG_DIVIDER  = 1'b0,
        STG_INTERVAL = 1'b1
    } stage_e;
endpackage

// File: rtl/cascade_byte_port.sv
// Byte sequencing for one 16-bit counter on an 8-bit host port.
// Writes go low byte first; the high byte emits a one-cycle load strobe
// with the assembled value. Reads go low byte first; the high byte is
// captured when the low byte is read. Assumes at most one access per cycle.
module cascade_byte_port #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              rd_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [VAL_W-1:0]  live_val,
    output logic              load_stb,
    output logic [VAL_W-1:0]  load_val,
    output logic              pending,
    output logic [BYTE_W-1:0] rd_byte
);
    logic              wr_hi_q;
    logic [BYTE_W-1:0] lo_hold_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] hi_snap_q;

    // Write pointer and low-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi_q   <= 1'b0;
            lo_hold_q <= '0;
        end else if (wr_sel) begin
            if (!wr_hi_q) lo_hold_q <= wr_byte;
            wr_hi_q <= !wr_hi_q;
        end
    end

    // Read pointer and high-byte capture taken at the low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi_q   <= 1'b0;
            hi_snap_q <= '0;
        end else if (rd_sel) begin
            if (!rd_hi_q) hi_snap_q <= live_val[VAL_W-1:BYTE_W];
            rd_hi_q <= !rd_hi_q;
        end
    end

    assign load_stb = wr_sel && wr_hi_q;
    assign load_val = {wr_byte, lo_hold_q};
    assign pending  = wr_hi_q;
    assign rd_byte  = rd_hi_q ? hi_snap_q : live_val[BYTE_W-1:0];
endmodule

// File: rtl/cascade_pair.sv
// One divider feeding one interval counter.
// The divider counts accepted ticks and reloads at 1 or 0, giving a cascade
// step. The interval counter decrements on each step, and a step that finds
// it at zero produces a one-clock interrupt pulse. Assumes the load strobes
// arrive only while halt is high, or for the interval counter at any time.
module cascade_pair #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             div_load,
    input  logic [CNT_W-1:0] div_val,
    input  logic             ivl_load,
    input  logic [CNT_W-1:0] ivl_val,
    output logic [CNT_W-1:0] div_cnt,
    output logic [CNT_W-1:0] ivl_cnt,
    output logic             irq_pulse
);
    logic             running_q;
    logic [CNT_W-1:0] divisor_q;
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] post_q;
    logic             pulse_q;
    logic             advance;
    logic             step;

    // An accepted tick, and whether it lands on the divider's terminal count.
    always_comb begin
        advance = tick_en && running_q && !halt;
        step    = advance && (pre_q <= CNT_W'(1));
    end

    // Divider: load, then count down and reload on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            divisor_q <= '0;
            pre_q     <= '0;
        end else if (div_load) begin
            running_q <= 1'b1;
            divisor_q <= div_val;
            pre_q     <= div_val;
        end else if (advance) begin
            pre_q <= step ? divisor_q : pre_q - CNT_W'(1);
        end
    end

    // Interval counter: host load wins, else step down with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        post_q <= '0;
        else if (ivl_load) post_q <= ivl_val;
        else if (step)     post_q <= post_q - CNT_W'(1);
    end

    // Interrupt pulse: one cycle after a step that found the counter at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= step && (post_q == '0);
    end

    assign div_cnt   = pre_q;
    assign ivl_cnt   = post_q;
    assign irq_pulse = pulse_q;
endmodule

// File: rtl/cascade_timer.sv
// Top of the cascaded timer block: a byte port per counter and a
// divider/interval pair per timer, with each pair routed to a fixed
// bit of the interrupt vector. Address = {pair, stage}.
module cascade_timer
    import cascade_timer_pkg::*;
#(
    parameter logic [PAIRS*IRQ_IDX_W-1:0] IRQ_MAP = {3'd0, 3'd6}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [IRQ_W-1:0]  irq_lines
);
    logic [CTRS-1:0]        wr_sel;
    logic [CTRS-1:0]        rd_sel;
    logic [CTRS-1:0]        load_stb;
    logic [CTRS-1:0]        pending;
    logic [CNT_W-1:0]       load_val [CTRS];
    logic [CNT_W-1:0]       live_val [CTRS];
    logic [BYTE_W-1:0]      rd_byte  [CTRS];
    logic [PAIRS-1:0]       pair_halt;
    logic [PAIRS-1:0]       div_ld;
    logic [PAIRS-1:0]       pair_irq;
    logic [PAIRS*CNT_W-1:0] div_cnt_flat;

    // One byte port per counter, selected by the address.
    for (genvar k = 0; k < CTRS; k++) begin : g_port
        assign wr_sel[k] = wr_en && (addr == SEL_W'(k));
        assign rd_sel[k] = rd_en && (addr == SEL_W'(k));
        cascade_byte_port #(.BYTE_W(BYTE_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel[k]),
            .rd_sel   (rd_sel[k]),
            .wr_byte  (wr_data),
            .live_val (live_val[k]),
            .load_stb (load_stb[k]),
            .load_val (load_val[k]),
            .pending  (pending[k]),
            .rd_byte  (rd_byte[k])
        );
    end

    // One divider/interval pair per timer; halted while any half-write is open.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        localparam int DIV_IDX = p * STAGES + int'(STG_DIVIDER);
        localparam int IVL_IDX = p * STAGES + int'(STG_INTERVAL);
        assign pair_halt[p] = pending[DIV_IDX] || pending[IVL_IDX];
        assign div_ld[p]    = load_stb[DIV_IDX];
        assign div_cnt_flat[p*CNT_W +: CNT_W] = live_val[DIV_IDX];
        cascade_pair #(.CNT_W(CNT_W)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .halt      (pair_halt[p]),
            .div_load  (load_stb[DIV_IDX]),
            .div_val   (load_val[DIV_IDX]),
            .ivl_load  (load_stb[IVL_IDX]),
            .ivl_val   (load_val[IVL_IDX]),
            .div_cnt   (live_val[DIV_IDX]),
            .ivl_cnt   (live_val[IVL_IDX]),
            .irq_pulse (pair_irq[p])
        );
    end

    // Route each pair's pulse onto its assigned vector bit.
    always_comb begin
        irq_lines = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (pair_irq[p]) irq_lines[IRQ_MAP[p*IRQ_IDX_W +: IRQ_IDX_W]] = 1'b1;
        end
    end

    assign rd_data = rd_byte[addr];
endmodule

// File: rtl/cascade_timer_checker.sv
// Cycle-by-cycle properties of the cascaded timer, attached by bind.
// Observes the tick input, the vector output and each pair's divider state.
module cascade_timer_checker
    import cascade_timer_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_en,
    input logic [IRQ_W-1:0]       irq_lines,
    input logic [PAIRS-1:0]       pair_halt,
    input logic [PAIRS-1:0]       div_ld,
    input logic [PAIRS*CNT_W-1:0] div_cnt_flat
);
    // R1: the vector is clear in the cycle after any reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_lines == '0));

    // R8: an interrupt comes only one edge after a tick.
    assert_irq_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != '0) |-> $past(tick_en));

    for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
        // R8: every interrupt bit is one cycle wide.
        assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lines[b] |=> !irq_lines[b]);
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // R4: a half-written value freezes the pair's divider.
        assert_halt_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_halt[p] && !div_ld[p]) |=> $stable(div_cnt_flat[p*CNT_W +: CNT_W]));

        // R6: the divider moves only on a tick or a load.
        assert_no_tick_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick_en && !div_ld[p]) |=> $stable(div_cnt_flat[p*CNT_W +: CNT_W]));
    end
endmodule

bind cascade_timer cascade_timer_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .irq_lines    (irq_lines),
    .pair_halt    (pair_halt),
    .div_ld       (div_ld),
    .div_cnt_flat (div_cnt_flat)
);

// File: tb/cascade_timer_test.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module cascade_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [7:0] irq_lines;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = !clk;

    cascade_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_lines (irq_lines)
    );

    // Vectors: pair, divisor, interval start, ticks -> irqs, divider end, interval end.
    localparam int NV = 8;
    localparam int V_PAIR [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
    localparam int V_DIV  [NV] = '{3, 1, 0, 2, 256, 1, 5, 2};
    localparam int V_IVL  [NV] = '{0, 2, 1, 1, 0, 0, 0, 1};
    localparam int V_TCK  [NV] = '{7, 5, 4, 8, 255, 3, 4, 8};
    localparam int V_IRQ  [NV] = '{1, 1, 1, 1, 0, 1, 0, 1};
    localparam int V_PRE  [NV] = '{2, 1, 0, 2, 1, 1, 1, 2};
    localparam int V_POST [NV] = '{'hFFFE, 'hFFFD, 'hFFFD, 'hFFFD, 0, 'hFFFD, 0, 'hFFFD};

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr8(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [1:0] a, input logic [15:0] v);
        wr8(a, v[7:0]);
        wr8(a, v[15:8]);
    endtask

    task automatic rd8(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(a, lo);
        rd8(a, hi);
        v = {hi, lo};
    endtask

    // One tick; returns the vector seen in the cycle after the accepting edge.
    task automatic tick(output logic [7:0] seen);
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        seen = irq_lines;
    endtask

    task automatic ticks(input int n, output int hits);
        logic [7:0] s;
        hits = 0;
        for (int i = 0; i < n; i++) begin
            tick(s);
            if (s != 8'd0) hits++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b, s;
        int          hits;

        // Table walk: R2 routing, R6 reload period, R7 wrap, R8 line choice.
        for (int k = 0; k < NV; k++) begin
            int line, other, on_line, stray;
            line  = (V_PAIR[k] == 0) ? 6 : 0;
            other = (V_PAIR[k] == 0) ? 0 : 6;
            do_reset();
            wr16(2'(V_PAIR[k] * 2), 16'(V_DIV[k]));
            wr16(2'(V_PAIR[k] * 2 + 1), 16'(V_IVL[k]));
            on_line = 0;
            stray   = 0;
            for (int t = 0; t < V_TCK[k]; t++) begin
                tick(s);
                if (s[line]) on_line++;
                if (s[other]) stray++;
            end
            check($sformatf("R7 vec%0d irq count", k), on_line, V_IRQ[k]);
            check($sformatf("R8 vec%0d other line", k), stray, 0);
            rd16(2'(V_PAIR[k] * 2), v);
            check($sformatf("R6 vec%0d divider", k), int'(v), V_PRE[k]);
            rd16(2'(V_PAIR[k] * 2 + 1), v);
            check($sformatf("R2 vec%0d interval", k), int'(v), V_POST[k]);
        end

        // R1: reset state on all four counters and the vector.
        do_reset();
        @(negedge clk);
        check("R1 vector after reset", int'(irq_lines), 0);
        for (int a = 0; a < 4; a++) begin
            rd16(2'(a), v);
            check($sformatf("R1 counter %0d after reset", a), int'(v), 0);
        end
        // R5: idle pair ignores ticks, even with the interval counter loaded.
        ticks(3, hits);
        check("R5 no irq before load", hits, 0);
        wr16(2'd1, 16'd0);
        ticks(3, hits);
        check("R5 interval-only load idle", hits, 0);
        rd16(2'd1, v);
        check("R5 interval unchanged", int'(v), 0);

        // R3/R4: split writes and halting.
        do_reset();
        wr16(2'd0, 16'd2);
        wr16(2'd1, 16'd5);
        tick(s);
        wr8(2'd0, 8'd3);
        rd16(2'd0, v);
        check("R3 low byte alone no load", int'(v), 1);
        ticks(4, hits);
        rd16(2'd0, v);
        check("R4 divider frozen", int'(v), 1);
        rd16(2'd1, v);
        check("R4 interval frozen", int'(v), 5);
        wr8(2'd0, 8'd0);
        rd16(2'd0, v);
        check("R3 high byte loads", int'(v), 3);
        ticks(3, hits);
        rd16(2'd1, v);
        check("R6 step after new divisor", int'(v), 4);
        wr8(2'd1, 8'd0);
        ticks(2, hits);
        rd16(2'd0, v);
        check("R4 interval half-write halts pair", int'(v), 3);
        wr8(2'd1, 8'd0);
        tick(s);
        tick(s);
        tick(s);
        check("R7 irq on pair 0 line", int'(s), 8'h40);
        @(negedge clk);
        check("R8 pulse one cycle", int'(irq_lines), 0);

        // R9: high byte captured at the low-byte read.
        do_reset();
        wr16(2'd0, 16'h0201);
        wr16(2'd1, 16'h0100);
        tick(s);
        rd8(2'd0, b);
        check("R9 low byte live", int'(b), 8'h00);
        tick(s);
        rd8(2'd0, b);
        check("R9 high byte captured", int'(b), 8'h02);
        rd16(2'd0, v);
        check("R9 fresh read", int'(v), 16'h01FF);

        // R10: interval reload mid-run keeps divider phase.
        do_reset();
        wr16(2'd0, 16'd4);
        wr16(2'd1, 16'd0);
        ticks(2, hits);
        wr16(2'd1, 16'd3);
        ticks(2, hits);
        check("R10 no irq after reload", hits, 0);
        rd16(2'd0, v);
        check("R10 divider not restarted", int'(v), 4);
        rd16(2'd1, v);
        check("R10 interval stepped once", int'(v), 2);

        // R1: reset during a run returns the pair to idle.
        do_reset();
        ticks(3, hits);
        check("R1 idle after mid-run reset", hits, 0);
        rd16(2'd1, v);
        check("R1 interval cleared", int'(v), 0);

        finish_run();
    end
endmodule